// File: doc/BRIEF.md
# Codec Control Slot Access Engine

This block carries register accesses from a processor bus to an external audio codec through the two control slots of the audio link frame: an address slot and a data slot. Software loads the data slot transmit register first (for a codec write), then writes the address slot transmit register. That second write starts one codec access. The access is a read or a write, chosen by a single bit of the written word. The engine presents the access to the codec side as a request/acknowledge transfer and keeps its fields steady until the codec acknowledges.

When a read completes, the engine places the returned codec word in the data slot receive register, left-aligned as it would sit in the frame slot. It places a copy of the launching address word, with the direction bit cleared, in the address slot receive register. A flag register tracks progress: transmit-empty, receive-busy and receive-valid bits for each slot. The sample slots, the serial bit timing and the codec itself sit outside this block.

Top module: `codec_slot_engine`

## Requirements
- R1: After reset, the flag register (select 4) reads 0x07, with bit 0 address-slot tx empty, bit 1 data-slot tx empty and bit 2 combined tx empty set. Every other flag is 0. The four slot registers (selects 0 address tx, 1 data tx, 2 address rx, 3 data rx) read 0, and `cdc_req_o` is low.
- R2: A bus write to select 1 stores the full 32-bit word, which reads back unchanged, and clears flag bit 1.
- R3: A bus write to select 0 while idle stores the word, clears flag bit 0 and raises `cdc_req_o` one cycle later. `cdc_rd_o` equals word bit 19 (1 = read, 0 = write), and `cdc_addr_o` equals word bits 18:12.
- R4: `cdc_wdata_o` equals bits 19:4 of the select 1 register as it stood when the access was launched.
- R5: While `cdc_ack_i` is low, `cdc_req_o` and its read flag, address and data stay unchanged. `cdc_req_o` drops in the cycle after the acknowledge is sampled.
- R6: On read completion, select 2 holds the launching select 0 word with bit 19 cleared, and select 3 holds `cdc_rdata_i` shifted left by 4.
- R7: Launching a read sets flag bits 3 and 4 (rx busy) and clears bits 5 and 6 (rx valid). Read completion clears bits 3 and 4 and sets bits 5 and 6.
- R8: Completion of a write access leaves selects 2 and 3 and flag bits 5 and 6 unchanged.
- R9: A select 0 write while an access is outstanding is ignored. The register keeps its old word, and exactly one codec acknowledge is consumed with no further request.
- R10: Acknowledge of any access sets flag bits 0 and 1 again.
- R11: Flag bit 2 reads 1 exactly when bits 0 and 1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 3 | Register select (0..4) |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational on select) |
| cdc_req_o | output | 1 | Codec access request |
| cdc_rd_o | output | 1 | Access direction, 1 = read |
| cdc_addr_o | output | 7 | Codec register address |
| cdc_wdata_o | output | 16 | Codec write data |
| cdc_ack_i | input | 1 | Codec acknowledge, one cycle |
| cdc_rdata_i | input | 16 | Codec read data, valid with acknowledge |

## Verification
A register write lands on the clock edge that follows its strobe. The request and the cleared flag bits are visible one cycle after that edge. Receive registers, busy/valid flags and the re-set empty flags appear one cycle after the edge that samples the acknowledge, and the request drops in that same cycle. The bench drives strobes and the stub's acknowledge on falling edges and samples on falling edges only. It reads flags and receive registers at the first falling edge where the request is seen low, so each check lands exactly one register stage after its cause. A codec stub with a per-test latency, including zero, exercises both the held-request and the back-to-back acknowledge timing.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
  typedef enum logic [2:0] {
    SEL_S1TX  = 3'd0,
    SEL_S2TX  = 3'd1,
    SEL_S1RX  = 3'd2,
    SEL_S2RX  = 3'd3,
    SEL_FLAGS = 3'd4
  } reg_sel_e;

  // bit 0 is s1_tx_empty
  typedef struct packed {
    logic s2_rx_valid;
    logic s1_rx_valid;
    logic s2_rx_busy;
    logic s1_rx_busy;
    logic s12_tx_empty;
    logic s2_tx_empty;
    logic s1_tx_empty;
  } slot_flags_t;

  localparam int FLAG_W = $bits(slot_flags_t);
endpackage

// File: rtl/codec_slot_regs.sv
module codec_slot_regs #(
  parameter int WORD_W   = 32,
  parameter int CDATA_W  = 16,
  parameter int RW_BIT   = 19,
  parameter int DATA_LSB = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_s1_i,
  input  logic               wr_s2_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic               done_rd_i,
  input  logic [CDATA_W-1:0] rdata_i,
  output logic [WORD_W-1:0]  s1_tx_o,
  output logic [WORD_W-1:0]  s2_tx_o,
  output logic [WORD_W-1:0]  s1_rx_o,
  output logic [WORD_W-1:0]  s2_rx_o
);
  localparam logic [WORD_W-1:0] RW_MASK = WORD_W'(1) << RW_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_tx_o <= '0;
      s2_tx_o <= '0;
      s1_rx_o <= '0;
      s2_rx_o <= '0;
    end else begin
      if (wr_s1_i) s1_tx_o <= wdata_i;
      if (wr_s2_i) s2_tx_o <= wdata_i;
      if (done_rd_i) begin
        s1_rx_o <= s1_tx_o & ~RW_MASK;
        s2_rx_o <= WORD_W'(rdata_i) << DATA_LSB;
      end
    end
  end
endmodule

// File: rtl/codec_slot_xact.sv
module codec_slot_xact #(
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               launch_rd_i,
  input  logic [CADDR_W-1:0] launch_addr_i,
  input  logic [CDATA_W-1:0] launch_wdata_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               rd_o,
  output logic [CADDR_W-1:0] addr_o,
  output logic [CDATA_W-1:0] wdata_o,
  output logic               done_o,
  output logic               done_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      rd_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (!req_o) begin
      if (launch_i) begin
        req_o   <= 1'b1;
        rd_o    <= launch_rd_i;
        addr_o  <= launch_addr_i;
        wdata_o <= launch_wdata_i;
      end
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  assign done_o    = req_o & ack_i;
  assign done_rd_o = done_o & rd_o;
endmodule

// File: rtl/codec_slot_flags.sv
module codec_slot_flags
  import codec_slot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  logic        launch_rd_i,
  input  logic        wr_s2_i,
  input  logic        done_i,
  input  logic        done_rd_i,
  output slot_flags_t flags_o
);
  logic s1_empty_q, s2_empty_q, busy_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_empty_q <= 1'b1;
      s2_empty_q <= 1'b1;
      busy_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      if (launch_i) begin
        s1_empty_q <= 1'b0;
        if (launch_rd_i) begin
          busy_q  <= 1'b1;
          valid_q <= 1'b0;
        end
      end
      if (done_i) begin
        s1_empty_q <= 1'b1;
        s2_empty_q <= 1'b1;
        if (done_rd_i) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
      // a fresh data word outranks the completion re-arm
      if (wr_s2_i) s2_empty_q <= 1'b0;
    end
  end

  always_comb begin
    flags_o              = '0;
    flags_o.s1_tx_empty  = s1_empty_q;
    flags_o.s2_tx_empty  = s2_empty_q;
    flags_o.s12_tx_empty = s1_empty_q & s2_empty_q;
    flags_o.s1_rx_busy   = busy_q;
    flags_o.s2_rx_busy   = busy_q;
    flags_o.s1_rx_valid  = valid_q;
    flags_o.s2_rx_valid  = valid_q;
  end
endmodule

// File: rtl/codec_slot_engine.sv
module codec_slot_engine
  import codec_slot_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CADDR_W  = 7,
  parameter int CDATA_W  = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12,
  parameter int DATA_LSB = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [2:0]         bus_sel_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic               cdc_req_o,
  output logic               cdc_rd_o,
  output logic [CADDR_W-1:0] cdc_addr_o,
  output logic [CDATA_W-1:0] cdc_wdata_o,
  input  logic               cdc_ack_i,
  input  logic [CDATA_W-1:0] cdc_rdata_i
);
  logic              wr_s1, wr_s2, launch_rd, done, done_rd;
  logic [WORD_W-1:0] s1_tx, s2_tx, s1_rx, s2_rx;
  slot_flags_t       flags;

  assign wr_s1     = bus_we_i && (bus_sel_i == SEL_S1TX) && !cdc_req_o;
  assign wr_s2     = bus_we_i && (bus_sel_i == SEL_S2TX);
  assign launch_rd = bus_wdata_i[RW_BIT];

  codec_slot_regs #(
    .WORD_W(WORD_W), .CDATA_W(CDATA_W), .RW_BIT(RW_BIT), .DATA_LSB(DATA_LSB)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_s1_i(wr_s1), .wr_s2_i(wr_s2), .wdata_i(bus_wdata_i),
    .done_rd_i(done_rd), .rdata_i(cdc_rdata_i),
    .s1_tx_o(s1_tx), .s2_tx_o(s2_tx), .s1_rx_o(s1_rx), .s2_rx_o(s2_rx)
  );

  codec_slot_xact #(.CADDR_W(CADDR_W), .CDATA_W(CDATA_W)) u_xact (
    .clk_i, .rst_ni,
    .launch_i(wr_s1), .launch_rd_i(launch_rd),
    .launch_addr_i(bus_wdata_i[ADDR_LSB +: CADDR_W]),
    .launch_wdata_i(s2_tx[DATA_LSB +: CDATA_W]),
    .ack_i(cdc_ack_i),
    .req_o(cdc_req_o), .rd_o(cdc_rd_o), .addr_o(cdc_addr_o), .wdata_o(cdc_wdata_o),
    .done_o(done), .done_rd_o(done_rd)
  );

  codec_slot_flags u_flags (
    .clk_i, .rst_ni,
    .launch_i(wr_s1), .launch_rd_i(launch_rd), .wr_s2_i(wr_s2),
    .done_i(done), .done_rd_i(done_rd), .flags_o(flags)
  );

  always_comb begin
    case (bus_sel_i)
      SEL_S1TX:  bus_rdata_o = s1_tx;
      SEL_S2TX:  bus_rdata_o = s2_tx;
      SEL_S1RX:  bus_rdata_o = s1_rx;
      SEL_S2RX:  bus_rdata_o = s2_rx;
      SEL_FLAGS: bus_rdata_o = WORD_W'(flags);
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/codec_slot_engine_chk.sv
module codec_slot_engine_chk
  import codec_slot_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CADDR_W  = 7,
  parameter int CDATA_W  = 16,
  parameter int DATA_LSB = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [2:0]         bus_sel_i,
  input logic               cdc_req_o,
  input logic               cdc_rd_o,
  input logic [CADDR_W-1:0] cdc_addr_o,
  input logic [CDATA_W-1:0] cdc_wdata_o,
  input logic               cdc_ack_i,
  input logic [CDATA_W-1:0] cdc_rdata_i,
  input slot_flags_t        flags,
  input logic [WORD_W-1:0]  s1_tx,
  input logic [WORD_W-1:0]  s2_rx
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && !cdc_ack_i |=> cdc_req_o && $stable(cdc_rd_o) && $stable(cdc_addr_o)
                                && $stable(cdc_wdata_o)); // R5
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && cdc_ack_i |=> !cdc_req_o); // R5
  AST_PENDING_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o |-> !flags.s1_tx_empty); // R3
  AST_READ_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && cdc_ack_i && cdc_rd_o |=> flags.s1_rx_valid && flags.s2_rx_valid
                                         && !flags.s1_rx_busy && !flags.s2_rx_busy); // R7
  AST_RX_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && cdc_ack_i && cdc_rd_o |=> s2_rx == (WORD_W'($past(cdc_rdata_i)) << DATA_LSB)); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && bus_we_i && bus_sel_i == SEL_S1TX |=> $stable(s1_tx)); // R9
  AST_DONE_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdc_req_o && cdc_ack_i && !(bus_we_i && bus_sel_i == SEL_S2TX)
      |=> flags.s1_tx_empty && flags.s2_tx_empty); // R10
endmodule

bind codec_slot_engine codec_slot_engine_chk #(
  .WORD_W(WORD_W), .CADDR_W(CADDR_W), .CDATA_W(CDATA_W), .DATA_LSB(DATA_LSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
  .cdc_req_o(cdc_req_o), .cdc_rd_o(cdc_rd_o), .cdc_addr_o(cdc_addr_o),
  .cdc_wdata_o(cdc_wdata_o), .cdc_ack_i(cdc_ack_i), .cdc_rdata_i(cdc_rdata_i),
  .flags(flags), .s1_tx(s1_tx), .s2_rx(s2_rx)
);

// File: tb/codec_slot_engine_tb.sv
`timescale 1ns/1ps
module codec_slot_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, rd;
  logic [6:0]  addr;
  logic [15:0] cwdata;
  logic        ack = 1'b0;
  logic [15:0] crdata = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int lat = 0;
  int cnt = 0;
  int n_acks = 0;
  logic       cap_rd = 1'b0;
  logic [6:0] cap_addr = '0;
  logic [15:0] cap_wdata = '0;

  always #4 clk = ~clk;

  codec_slot_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_sel_i(sel), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cdc_req_o(req), .cdc_rd_o(rd), .cdc_addr_o(addr),
    .cdc_wdata_o(cwdata), .cdc_ack_i(ack), .cdc_rdata_i(crdata)
  );

  function automatic logic [15:0] stub_val(logic [6:0] a);
    return {a, 9'h000} ^ 16'h5A3C;
  endfunction

  // behavioural codec: acknowledges after lat idle cycles
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (req) begin
      if (cnt >= lat) begin
        ack = 1'b1;
        crdata = stub_val(addr);
        cap_rd = rd; cap_addr = addr; cap_wdata = cwdata;
        n_acks++;
        cnt = 0;
      end else cnt++;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] s, output logic [31:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 50 && req; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(3'd4, v); check("R1 flags", v, 32'h07);
    check("R11 combined at reset", {31'b0, v[2]}, 32'd1);
    for (int s = 0; s < 4; s++) begin
      bus_read(3'(s), v); check("R1 slot reg", v, 32'h0);
    end
    check("R1 req", {31'b0, req}, 32'd0);
  endtask

  task automatic t_slot2();
    logic [31:0] v;
    bus_write(3'd1, 32'hF00A_BCD7);
    bus_read(3'd1, v); check("R2 readback", v, 32'hF00A_BCD7);
    bus_read(3'd4, v); check("R2 flags", v, 32'h01);
    check("R11 combined cleared", {31'b0, v[2]}, 32'd0);
  endtask

  task automatic t_write_xact();
    logic [31:0] v;
    logic [6:0] a0;
    lat = 3;
    bus_write(3'd1, 32'h0001_2340);
    bus_write(3'd0, (32'h2A << 12) | 32'h0000_0F03);
    check("R3 req", {31'b0, req}, 32'd1);
    check("R3 rd", {31'b0, rd}, 32'd0);
    check("R3 addr", {25'b0, addr}, 32'h2A);
    check("R4 wdata", {16'b0, cwdata}, 32'h1234);
    bus_read(3'd4, v); check("R3 flags pending", v, 32'h00);
    a0 = addr;
    @(negedge clk);
    check("R5 held req", {31'b0, req}, 32'd1);
    check("R5 held addr", {25'b0, addr}, {25'b0, a0});
    wait_done();
    check("R4 codec saw data", {16'b0, cap_wdata}, 32'h1234);
    bus_read(3'd4, v); check("R10 flags after write", v, 32'h07);
    bus_read(3'd2, v); check("R8 s1 rx untouched", v, 32'h0);
    bus_read(3'd3, v); check("R8 s2 rx untouched", v, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    logic [31:0] w;
    lat = 2;
    w = (32'h1 << 19) | (32'h15 << 12) | 32'h5;
    bus_write(3'd0, w);
    check("R3 rd", {31'b0, rd}, 32'd1);
    check("R3 addr", {25'b0, addr}, 32'h15);
    bus_read(3'd4, v); check("R7 busy flags", v, 32'h1A);
    wait_done();
    check("R5 dropped after ack", {31'b0, req}, 32'd0);
    bus_read(3'd2, v); check("R6 s1 rx", v, (32'h15 << 12) | 32'h5);
    bus_read(3'd3, v); check("R6 s2 rx", v, {12'b0, stub_val(7'h15), 4'b0});
    bus_read(3'd4, v); check("R7 valid flags", v, 32'h67);
  endtask

  task automatic t_write_keeps_valid();
    logic [31:0] v;
    lat = 0;
    bus_write(3'd0, 32'h0007_7000);
    wait_done();
    check("R4 codec saw data", {16'b0, cap_wdata}, 32'h1234);
    bus_read(3'd4, v); check("R8 valid kept", v, 32'h67);
    bus_read(3'd2, v); check("R8 s1 rx kept", v, (32'h15 << 12) | 32'h5);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    logic [31:0] wa;
    int base;
    lat = 6;
    base = n_acks;
    wa = (32'h1 << 19) | (32'h33 << 12);
    bus_write(3'd0, wa);
    bus_write(3'd0, 32'h0004_4000);
    bus_read(3'd0, v); check("R9 s1 tx kept", v, wa);
    check("R9 addr kept", {25'b0, addr}, 32'h33);
    wait_done();
    repeat (5) @(negedge clk);
    check("R9 single ack", 32'(n_acks - base), 32'd1);
    check("R9 no new req", {31'b0, req}, 32'd0);
    bus_read(3'd3, v); check("R6 s2 rx", v, {12'b0, stub_val(7'h33), 4'b0});
    bus_read(3'd4, v); check("R10 flags", v, 32'h67);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot2();
    t_write_xact();
    t_read();
    t_write_keeps_valid();
    t_ignore();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule